// File: doc/BRIEF.md
# Display Frame Fetch Timing Generator

This block produces the frame-level timing for a character-row display engine. It runs at the processor cycle rate, which is the colour subcarrier divided by four. A free-running frame counter counts the 14934 processor cycles of one frame: 262 lines of 57 cycles each. Fixed and programmable comparators decode three events from that count.

The first event is a one-cycle frame strobe, which feeds the processor's interrupt input. The second is a mode flag that moves bus ownership from the processor to the display side at a fixed point in the frame. The third is an active-low bus-request output that asks the processor to give up its bus while one row of cards is fetched. Twelve fetch windows follow one another at a pitch of 912 cycles. A 3-bit vertical-delay value moves all of them by 114 cycles per step. The delay is captured once per frame. When the captured delay is zero, a thirteenth fetch window is added after the twelfth.

Every output is registered and is decoded from the value the counter will hold in the following cycle. Each output therefore lines up exactly with the count it belongs to.

Top module: `frame_dma_timer`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears the frame count to 0 and drives `busreq_n` high, `disp_mode` low and `vint_strobe` low. The state right after reset is cycle 0 of a frame that carries no strobe.
- R2: The frame count advances by one each cycle from 0 to 14933, then wraps to 0. `vint_strobe` is high for exactly one cycle, at count 0 of every frame that starts by wrapping. It is low in every other cycle.
- R3: `disp_mode` is low for counts 0 to 3789 and high for counts 3790 to 14933.
- R4: With captured delay v (0 to 7), `busreq_n` is low at count c exactly when 3933 + 114*v + 912*r <= c < 4043 + 114*v + 912*r for some row r in 0 to 11. It is high at every other count, so each window lasts 110 cycles.
- R5: Only when v = 0, a further window with r = 12 starts at count 14877. It is cut short at the end of the frame (counts 14877 to 14933, 57 cycles), so the frame holds 13 requests instead of 12.
- R6: `vdelay` is captured at the edge that moves the count to 0 and at every reset edge. A change of `vdelay` at any other time has no effect on the current frame's windows.
- R7: `busreq_n` is never low while `disp_mode` is low, and no low pulse of `busreq_n` lasts longer than 110 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| vdelay | input | 3 | Vertical delay in row-line steps, captured at frame start |
| busreq_n | output | 1 | Active-low bus request for a card-row fetch |
| disp_mode | output | 1 | High while the display side owns the bus |
| vint_strobe | output | 1 | One-cycle frame-start interrupt strobe |

## Verification
The hardest case to reach is the thirteenth fetch. It exists only when the delay captured at the wrap is zero, and its window runs into the frame boundary, so it is visible only in the last 57 cycles of such a frame. The bench sets the delay to zero during the frame before. It then compares every cycle of the following frame against the window formula, including the truncated window, and counts the total low cycles. The capture point is tested the same way. The delay is changed in the middle of a frame and again in the very last cycle of a frame, and the bench checks that only the next frame follows the new value.

// File: rtl/frame_dma_pkg.sv
package frame_dma_pkg;

  // Start count of a fetch window for a given delay step and row index.
  function automatic int unsigned fdt_win_start(
      input int unsigned base,
      input int unsigned vd_step,
      input int unsigned row_step,
      input int unsigned vd,
      input int unsigned row);
    return base + vd_step * vd + row_step * row;
  endfunction

  // Registered output bundle of the generator.
  typedef struct packed {
    logic req_n;
    logic disp;
    logic vint;
  } fdt_out_t;

  localparam fdt_out_t FDT_OUT_IDLE = '{req_n: 1'b1, disp: 1'b0, vint: 1'b0};

endpackage

// File: rtl/fdt_frame_counter.sv
module fdt_frame_counter #(
  parameter int unsigned FRAME_CYCLES = 14934,
  localparam int unsigned CNT_W = $clog2(FRAME_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

  assign wrap     = (cnt_q == LAST);
  assign cnt_next = wrap ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_next;
  end

endmodule

// File: rtl/fdt_vdelay_latch.sv
module fdt_vdelay_latch #(
  parameter int unsigned VD_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [VD_W-1:0] vd_in,
  output logic [VD_W-1:0] vd_q
);

  // The value is taken at reset and at each frame start, and held otherwise.
  always_ff @(posedge clk) begin
    if (rst || capture) vd_q <= vd_in;
  end

endmodule

// File: rtl/fdt_fetch_windows.sv
module fdt_fetch_windows
  import frame_dma_pkg::*;
#(
  parameter int unsigned ROWS       = 12,
  parameter int unsigned VD_W       = 3,
  parameter int unsigned CNT_W      = 14,
  parameter int unsigned FETCH_BASE = 3933,
  parameter int unsigned VD_STEP    = 114,
  parameter int unsigned ROW_STEP   = 912,
  parameter int unsigned FETCH_LEN  = 110
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [VD_W-1:0]  vd,
  output logic             any_hit
);

  // One comparator pair per row, plus one for the extra row used only at zero delay.
  localparam int unsigned NWIN = ROWS + 1;

  logic [NWIN-1:0] hit;
  logic [31:0]     cnt_w;
  logic            vd_zero;

  assign cnt_w   = 32'(cnt);
  assign vd_zero = (vd == '0);

  for (genvar r = 0; r < NWIN; r++) begin : g_win
    logic [31:0] w_start;
    logic [31:0] w_end;
    logic        en;

    assign w_start = 32'(fdt_win_start(FETCH_BASE, VD_STEP, ROW_STEP, 32'(vd), r));
    assign w_end   = w_start + 32'(FETCH_LEN);

    if (r < ROWS) begin : g_std
      assign en = 1'b1;
    end else begin : g_extra
      assign en = vd_zero;
    end

    assign hit[r] = en && (cnt_w >= w_start) && (cnt_w < w_end);
  end

  assign any_hit = |hit;

endmodule

// File: rtl/frame_dma_timer.sv
module frame_dma_timer
  import frame_dma_pkg::*;
#(
  parameter int unsigned FRAME_CYCLES = 14934,
  parameter int unsigned MODE_SWITCH  = 3790,
  parameter int unsigned ROWS         = 12,
  parameter int unsigned VD_W         = 3,
  parameter int unsigned FETCH_BASE   = 3933,
  parameter int unsigned VD_STEP      = 114,
  parameter int unsigned ROW_STEP     = 912,
  parameter int unsigned FETCH_LEN    = 110
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [VD_W-1:0] vdelay,
  output logic            busreq_n,
  output logic            disp_mode,
  output logic            vint_strobe
);

  localparam int unsigned CNT_W = $clog2(FRAME_CYCLES);
  localparam logic [CNT_W-1:0] MODE_AT = CNT_W'(MODE_SWITCH);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             wrap;
  logic [VD_W-1:0]  vd_q;
  logic             win_hit;
  fdt_out_t         out_d;
  fdt_out_t         out_q;

  fdt_frame_counter #(
    .FRAME_CYCLES (FRAME_CYCLES)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .cnt_q    (cnt_q),
    .cnt_next (cnt_next),
    .wrap     (wrap)
  );

  fdt_vdelay_latch #(
    .VD_W (VD_W)
  ) u_vd (
    .clk     (clk),
    .rst     (rst),
    .capture (wrap),
    .vd_in   (vdelay),
    .vd_q    (vd_q)
  );

  fdt_fetch_windows #(
    .ROWS       (ROWS),
    .VD_W       (VD_W),
    .CNT_W      (CNT_W),
    .FETCH_BASE (FETCH_BASE),
    .VD_STEP    (VD_STEP),
    .ROW_STEP   (ROW_STEP),
    .FETCH_LEN  (FETCH_LEN)
  ) u_win (
    .cnt     (cnt_next),
    .vd      (vd_q),
    .any_hit (win_hit)
  );

  // Decode the count of the coming cycle, so each registered output matches its count.
  always_comb begin
    out_d.req_n = ~win_hit;
    out_d.disp  = (cnt_next >= MODE_AT);
    out_d.vint  = wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= FDT_OUT_IDLE;
    else     out_q <= out_d;
  end

  assign busreq_n    = out_q.req_n;
  assign disp_mode   = out_q.disp;
  assign vint_strobe = out_q.vint;

endmodule

// File: rtl/frame_dma_timer_chk.sv
module frame_dma_timer_chk #(
  parameter int unsigned FRAME_CYCLES = 14934,
  parameter int unsigned MODE_SWITCH  = 3790,
  parameter int unsigned FETCH_LEN    = 110,
  localparam int unsigned CNT_W = $clog2(FRAME_CYCLES)
) (
  input logic             clk,
  input logic             rst,
  input logic             busreq_n,
  input logic             disp_mode,
  input logic             vint_strobe,
  input logic [CNT_W-1:0] cnt
);

  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || busreq_n) low_run <= '0;
    else                 low_run <= low_run + 1'b1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (busreq_n && !disp_mode && !vint_strobe && cnt == '0)); // R1

  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_W'(FRAME_CYCLES - 1)) |=> (cnt == '0)); // R2

  AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    vint_strobe |-> (cnt == '0)); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    vint_strobe |=> !vint_strobe); // R2

  AST_MODE_RISE_POINT: assert property (@(posedge clk) disable iff (rst)
    $rose(disp_mode) |-> (cnt == CNT_W'(MODE_SWITCH))); // R3

  AST_REQ_IN_DISPLAY: assert property (@(posedge clk) disable iff (rst)
    !busreq_n |-> disp_mode); // R7

  AST_REQ_MAX_LEN: assert property (@(posedge clk) disable iff (rst)
    !busreq_n |-> (low_run < 16'(FETCH_LEN))); // R7

endmodule

bind frame_dma_timer frame_dma_timer_chk #(
  .FRAME_CYCLES (FRAME_CYCLES),
  .MODE_SWITCH  (MODE_SWITCH),
  .FETCH_LEN    (FETCH_LEN)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busreq_n    (busreq_n),
  .disp_mode   (disp_mode),
  .vint_strobe (vint_strobe),
  .cnt         (cnt_q)
);

// File: tb/frame_dma_timer_bench.sv
`timescale 1ns/100ps
module frame_dma_timer_bench;

  localparam int FRAME = 14934;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] vdelay = 3'd3;
  logic       busreq_n;
  logic       disp_mode;
  logic       vint_strobe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  frame_dma_timer u_frame_dma_timer (
    .clk         (clk),
    .rst         (rst),
    .vdelay      (vdelay),
    .busreq_n    (busreq_n),
    .disp_mode   (disp_mode),
    .vint_strobe (vint_strobe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_req(input int c, input int v);
    int nrow = (v == 0) ? 13 : 12;
    for (int r = 0; r < nrow; r++) begin
      int s = 3933 + 114 * v + 912 * r;
      if (c >= s && c < s + 110) return 1'b1;
    end
    return 1'b0;
  endfunction

  // Runs one whole frame from count 0; called at a falling edge at count 0.
  task automatic run_frame(input int v, input bit strobe0, input string tag,
                           input int chg_at, input int chg_val);
    int err_req = 0, err_dm = 0, err_vi = 0;
    int a_req = 0, e_req = 0, a_dm = 0, e_dm = 0, a_vi = 0, e_vi = 0;
    int low_cycles = 0, falls = 0, strobes = 0;
    bit prev_req_n = 1'b1;
    for (int c = 0; c < FRAME; c++) begin
      bit er = exp_req(c, v);
      bit ed = (c >= 3790);
      bit ev = strobe0 && (c == 0);
      if (busreq_n != !er) begin
        if (err_req == 0) begin a_req = c; e_req = er; end
        err_req++;
      end
      if (disp_mode != ed) begin
        if (err_dm == 0) begin a_dm = c; e_dm = ed; end
        err_dm++;
      end
      if (vint_strobe != ev) begin
        if (err_vi == 0) begin a_vi = c; e_vi = ev; end
        err_vi++;
      end
      if (!busreq_n) low_cycles++;
      if (prev_req_n && !busreq_n) falls++;
      if (vint_strobe) strobes++;
      prev_req_n = busreq_n;
      if (c == chg_at) vdelay = 3'(chg_val);
      @(posedge clk);
      @(negedge clk);
    end
    chk(err_req == 0, tag, $sformatf("request pattern mismatches (first at count %0d, expected req %0d)", a_req, e_req), err_req, 0);
    chk(err_dm == 0, "R3", $sformatf("display mode mismatches (first at count %0d, expected %0d)", a_dm, e_dm), err_dm, 0);
    chk(err_vi == 0, "R2", $sformatf("strobe mismatches (first at count %0d, expected %0d)", a_vi, e_vi), err_vi, 0);
    chk(strobes == int'(strobe0), "R2", "strobes per frame", strobes, int'(strobe0));
    chk(falls == ((v == 0) ? 13 : 12), (v == 0) ? "R5" : "R4", "requests per frame", falls, (v == 0) ? 13 : 12);
    chk(low_cycles == ((v == 0) ? 12 * 110 + 57 : 12 * 110), (v == 0) ? "R5" : "R4",
        "request low cycles per frame", low_cycles, (v == 0) ? 12 * 110 + 57 : 12 * 110);
  endtask

  // Reset from power-up, then one frame at delay 3 with a mid-frame change that must not apply.
  task automatic t_reset_and_delay3;
    rst = 1'b1;
    vdelay = 3'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busreq_n == 1'b1, "R1", "busreq_n in reset", busreq_n, 1);
    chk(disp_mode == 1'b0, "R1", "disp_mode in reset", disp_mode, 0);
    chk(vint_strobe == 1'b0, "R1", "vint_strobe in reset", vint_strobe, 0);
    rst = 1'b0;
    run_frame(3, 1'b0, "R4/R6", 100, 0);
  endtask

  // Zero delay: extra window, cut at the frame end; change to 7 in mid-frame.
  task automatic t_delay_zero;
    run_frame(0, 1'b1, "R5/R6", 200, 7);
  endtask

  // Largest delay; new value put on the input in the frame's final cycle.
  task automatic t_delay_max_last_cycle_change;
    run_frame(7, 1'b1, "R4", FRAME - 1, 5);
  endtask

  task automatic t_delay5;
    run_frame(5, 1'b1, "R4/R6", -1, 0);
  endtask

  // Reset in the middle of a fetch window, then a clean frame at the delay held in reset.
  task automatic t_mid_frame_reset;
    for (int c = 0; c < 4600; c++) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk(busreq_n == 1'b0, "R4", "request low at count 4600 with delay 5", busreq_n, 0);
    chk(disp_mode == 1'b1, "R3", "display mode at count 4600", disp_mode, 1);
    rst = 1'b1;
    vdelay = 3'd1;
    @(posedge clk);
    @(negedge clk);
    chk(busreq_n == 1'b1, "R1", "busreq_n after mid-window reset", busreq_n, 1);
    chk(disp_mode == 1'b0, "R1", "disp_mode after mid-window reset", disp_mode, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    run_frame(1, 1'b0, "R1/R6", -1, 0);
  endtask

  initial begin
    t_reset_and_delay3();
    t_delay_zero();
    t_delay_max_last_cycle_change();
    t_delay5();
    t_mid_frame_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule